// File: doc/BRIEF.md
# Synchronized Button Press Counter

This block counts push-button presses in a single clock domain. The raw button level is asynchronous to the system clock. It first passes through a chain of flip-flops that resynchronizes it. A three-state Moore machine then watches the synchronized level and turns each press into exactly one clock-wide increment strobe, however long the button is held. The strobe advances a 16-bit press counter, whose value is driven straight to a 16-bit output, for example to light a row of LEDs.

Two reset paths exist. `rst_n` is an asynchronous, active-low power-on reset that is released synchronously outside the block. `clear` is a synchronous, active-high input that zeroes the counter and puts the press detector back in its idle state. The increment strobe is brought out as a port so that the press timing can be observed.

Top module: `press_count_top`

## Requirements
- R1: While `rst_n` is low, `count` is 16'h0000 and `inc_pulse` is 0, and both stay so at the first sample after release with the button low.
- R2: When `btn_raw` rises and stays high, `inc_pulse` is high in the interval after the third rising clock edge that samples it high, and `count` shows the new value after the fourth.
- R3: A press held for any number of cycles raises `inc_pulse` for exactly one cycle and adds exactly one to `count`. No further count occurs until the synchronized level has returned low.
- R4: A `btn_raw` high level that lasts for only one clock edge still produces exactly one `inc_pulse` and exactly one count.
- R5: When `clear` is sampled high on a rising edge, `count` becomes 16'h0000 and the detector returns to idle. `clear` has no effect on the synchronizer.
- R6: `clear` takes priority over an increment. If `clear` and `inc_pulse` are both high at an edge, `count` becomes 16'h0000.
- R7: If the button is still held when `clear` releases the detector to idle, the detector treats the held level as a new press and counts once more.
- R8: `count` is unsigned, with bit 15 as the most significant bit. Incrementing 16'hFFFF gives 16'h0000.
- R9: A `btn_raw` level that toggles on every clock yields one `inc_pulse` on every second cycle, and one count for each high sample.
- R10: `count` changes only on an edge where `inc_pulse` or `clear` is high. It changes by exactly +1 for an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of counter and press detector |
| btn_raw | input | 1 | Asynchronous button level, high while pressed |
| count | output | 16 | Number of presses counted, modulo 65536 |
| inc_pulse | output | 1 | One-cycle strobe marking an accepted press |

## Verification
If the detector sits in the wrong state, the fault shows at the ports within one cycle. A missed move to the held state brings a second `inc_pulse` on the next cycle and an extra count one edge later. A stuck held state means a fresh press never raises the strobe. If the synchronizer has the wrong number of stages, the strobe appears one cycle early or late, and the exact latency check sees it on the very first press. Counter faults appear as a wrong value one edge after the strobe, or as a missed wrap after 16'hFFFF.

// File: rtl/press_count_pkg.sv
package press_count_pkg;
  typedef enum logic [1:0] {
    PD_IDLE  = 2'd0,
    PD_PULSE = 2'd1,
    PD_HELD  = 2'd2
  } pd_state_t;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/press_oneshot.sv
module press_oneshot
  import press_count_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic level_in,
  output logic strobe
);
  pd_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (clear) begin
      state_d = PD_IDLE;
    end else begin
      unique case (state_q)
        PD_IDLE:  state_d = level_in ? PD_PULSE : PD_IDLE;
        PD_PULSE: state_d = level_in ? PD_HELD  : PD_IDLE;
        PD_HELD:  state_d = level_in ? PD_HELD  : PD_IDLE;
        default:  state_d = PD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PD_IDLE;
    else        state_q <= state_d;
  end

  assign strobe = (state_q == PD_PULSE);

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  // R2
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> ($past(level_in) && !$past(clear)));

  // R3
  held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_HELD && level_in && !clear) |=> !strobe);

  // R5
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !strobe);
endmodule

// File: rtl/press_counter.sv
module press_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [WIDTH-1:0] value
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] value_q, value_d;
  logic             value_en;

  assign value_en = clear | inc;

  always_comb begin
    if (clear) value_d = '0;
    else       value_d = value_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value_q <= '0;
    else if (value_en) value_q <= value_d;
  end

  assign value = value_q;

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (value == '0));

  // R8
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clear) |=> (value == $past(value) + ONE));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clear) |=> $stable(value));
endmodule

// File: rtl/press_count_top.sv
module press_count_top #(
  parameter int CNT_W     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             btn_raw,
  output logic [CNT_W-1:0] count,
  output logic             inc_pulse
);
  logic btn_sync_lvl;

  btn_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (btn_raw),
    .sync_out (btn_sync_lvl)
  );

  press_oneshot u_oneshot (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .level_in (btn_sync_lvl),
    .strobe   (inc_pulse)
  );

  press_counter #(.WIDTH(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .inc   (inc_pulse),
    .value (count)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (count == '0 && !inc_pulse));
endmodule

// File: tb/tb_press_count_top.sv
module tb_press_count_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 20;
  localparam int  WDOG = 200000;

  // {btn_raw driven, expected inc_pulse, expected count} after the next edge
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 16'd0}, {1'b1, 1'b0, 16'd0}, {1'b1, 1'b1, 16'd0},
    {1'b1, 1'b0, 16'd1}, {1'b1, 1'b0, 16'd1}, {1'b0, 1'b0, 16'd1},
    {1'b0, 1'b0, 16'd1}, {1'b0, 1'b0, 16'd1}, {1'b1, 1'b0, 16'd1},
    {1'b0, 1'b0, 16'd1}, {1'b0, 1'b1, 16'd1}, {1'b0, 1'b0, 16'd2},
    {1'b0, 1'b0, 16'd2}, {1'b1, 1'b0, 16'd2}, {1'b0, 1'b0, 16'd2},
    {1'b1, 1'b1, 16'd2}, {1'b0, 1'b0, 16'd3}, {1'b0, 1'b1, 16'd3},
    {1'b0, 1'b0, 16'd4}, {1'b0, 1'b0, 16'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clear;
  logic        btn_raw;
  logic [15:0] count;
  logic        inc_pulse;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  press_count_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .btn_raw   (btn_raw),
    .count     (count),
    .inc_pulse (inc_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; clear = 1'b0; btn_raw = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count", count, 16'd0);
    check("R1 inc", {15'd0, inc_pulse}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", count, 16'd0);

    // Vector walk: R2 latency, R3 long hold, R4 one-cycle press, R9 toggling
    for (int i = 0; i < NVEC; i++) begin
      btn_raw = VEC[i][17];
      @(negedge clk);
      check($sformatf("R2/R3/R4/R9 vec%0d inc", i), {15'd0, inc_pulse}, {15'd0, VEC[i][16]});
      check($sformatf("R2/R3/R4/R9 vec%0d count", i), count, VEC[i][15:0]);
    end

    // R6 clear while strobe high, then R7 recount of held press
    btn_raw = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 strobe before clear", {15'd0, inc_pulse}, 16'd1);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check("R6 count after clear", count, 16'd0);
    check("R5 detector idle", {15'd0, inc_pulse}, 16'd0);
    @(negedge clk);
    check("R7 held recount strobe", {15'd0, inc_pulse}, 16'd1);
    @(negedge clk);
    check("R7 held recount count", count, 16'd1);
    repeat (5) @(negedge clk);
    check("R3 still held no count", count, 16'd1);
    btn_raw = 1'b0;
    repeat (4) @(negedge clk);

    // R5 plain clear with no press pending
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check("R5 clear to zero", count, 16'd0);

    // R8 wrap: 65535 toggled presses, then one more
    for (int k = 0; k < 65535; k++) begin
      btn_raw = 1'b1; @(negedge clk);
      btn_raw = 1'b0; @(negedge clk);
    end
    repeat (5) @(negedge clk);
    check("R8 reach max", count, 16'hFFFF);
    check("R10 idle no strobe", {15'd0, inc_pulse}, 16'd0);
    btn_raw = 1'b1; @(negedge clk);
    btn_raw = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 wrap to zero", count, 16'h0000);

    // R1 asynchronous reset mid-count
    btn_raw = 1'b1; @(negedge clk);
    btn_raw = 1'b0;
    repeat (5) @(negedge clk);
    check("R10 one more count", count, 16'd1);
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1;
    check("R1 async reset", count, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after second release", count, 16'd0);

    summary();
  end
endmodule